// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a memory read or write burst. A column command arrives as a one-cycle `cmd_go` pulse. The pulse carries the starting column, a three-bit burst length code and an ordering select. Starting on the next clock, the block presents one column per cycle on `beat_col`, qualified by `beat_vld`. It raises `beat_end` together with the final beat of a bounded burst.

A `halt` pulse ends any burst early, including a full-page burst. A new `cmd_go` can arrive on any clock and replaces the burst in progress, so column commands may be issued back to back. The output stream has no back-pressure: the consumer must take each beat in the cycle it is shown. `beat_vld` is only a qualifier, and no ready signal exists. Data movement, bank and row handling, and the storage of the mode settings are handled elsewhere.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until the first `cmd_go`, both `beat_vld` and `beat_end` are low.
- R2: A `cmd_go` sampled on a clock edge makes the first beat appear after that same edge, equal to `cmd_col`. This holds even if a previous burst is still running, and that burst is abandoned.
- R3: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give exactly 1, 2, 4 and 8 beats. `beat_end` is high only with the last beat, and `beat_vld` is low on the cycle after it.
- R4: With `cmd_ilv` = 0 (sequential), the low bits of beat k equal (start + k) modulo the burst length. For example, length 4 from low bits 2 gives 2,3,0,1.
- R5: With `cmd_ilv` = 1 (interleaved), the low bits of beat k equal start XOR k. For example, length 8 from low bits 5 gives 5,4,7,6,1,0,3,2.
- R6: For a bounded burst, the column bits above the burst-length field keep the value of `cmd_col` on every beat.
- R7: Length code 3'b111 is a full-page burst. The whole 9-bit column increments by one per beat and wraps from 511 to 0, `cmd_ilv` is ignored, and `beat_end` never rises. The burst continues until `halt` or a new `cmd_go`.
- R8: A `halt` sampled at an edge without `cmd_go` makes `beat_vld` low after that edge. When `cmd_go` and `halt` arrive together, the new burst starts.
- R9: Reserved length codes 3'b100, 3'b101 and 3'b110 behave as length 1, whatever the value of `cmd_ilv`.
- R10: A length-1 burst presents exactly one beat, equal to `cmd_col`, with `beat_end` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | Column command strobe, starts a burst |
| cmd_col | input | 9 | Starting column of the burst |
| cmd_len | input | 3 | Burst length code |
| cmd_ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| halt | input | 1 | Ends the running burst |
| beat_vld | output | 1 | A beat column is presented this cycle |
| beat_col | output | 9 | Column address of the current beat |
| beat_end | output | 1 | Current beat is the last of a bounded burst |

## Verification
The hardest case to reach is a collision between events: a new command landing mid-burst, a halt landing on a particular beat, or a command and a halt on the same edge. A stream of isolated bursts never reaches any of them. The bench drives its inputs on the falling edge, so it can place `cmd_go` or `halt` on the exact cycle a given beat is being shown. Directed sequences then restart an 8-beat burst on its second beat, halt a full-page burst after it crosses the 511-to-0 wrap, and pulse both inputs together.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  typedef enum logic [2:0] {
    BLEN_1    = 3'b000,
    BLEN_2    = 3'b001,
    BLEN_4    = 3'b010,
    BLEN_8    = 3'b011,
    BLEN_PAGE = 3'b111
  } blen_code_e;

  localparam int unsigned CODE_W = 3;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [CODE_W-1:0] code,
  output logic [COL_W-1:0]  span_mask,
  output logic              page
);

  always_comb begin
    page      = 1'b0;
    span_mask = '0;
    case (code)
      BLEN_2:    span_mask = COL_W'(1);
      BLEN_4:    span_mask = COL_W'(3);
      BLEN_8:    span_mask = COL_W'(7);
      BLEN_PAGE: begin
        span_mask = '1;
        page      = 1'b1;
      end
      default:   span_mask = '0;
    endcase
  end

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] span_mask,
  input  logic             page,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);

  logic [COL_W-1:0] fixed_hi;
  logic [COL_W-1:0] seq_lo;
  logic [COL_W-1:0] ilv_lo;

  always_comb begin
    fixed_hi = base & ~span_mask;
    seq_lo   = (base + idx) & span_mask;
    ilv_lo   = (base ^ idx) & span_mask;
    if (page)
      addr = base + idx;
    else if (ilv)
      addr = fixed_hi | ilv_lo;
    else
      addr = fixed_hi | seq_lo;
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [CODE_W-1:0] cmd_len,
  input  logic              cmd_ilv,
  input  logic              halt,
  output logic              beat_vld,
  output logic [COL_W-1:0]  beat_col,
  output logic              beat_end
);

  logic [COL_W-1:0] dec_mask;
  logic             dec_page;

  logic             act_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] idx_q;
  logic [COL_W-1:0] mask_q;
  logic             page_q;
  logic             ilv_q;
  logic             at_final;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .code      (cmd_len),
    .span_mask (dec_mask),
    .page      (dec_page)
  );

  burst_addr_step #(.COL_W(COL_W)) u_step (
    .base      (base_q),
    .idx       (idx_q),
    .span_mask (mask_q),
    .page      (page_q),
    .ilv       (ilv_q),
    .addr      (beat_col)
  );

  assign at_final = !page_q && (idx_q == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      mask_q <= '0;
      page_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (cmd_go) begin
      act_q  <= 1'b1;
      base_q <= cmd_col;
      idx_q  <= '0;
      mask_q <= dec_mask;
      page_q <= dec_page;
      ilv_q  <= cmd_ilv & ~dec_page;
    end else if (halt) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      if (at_final)
        act_q <= 1'b0;
      else
        idx_q <= idx_q + 1'b1;
    end
  end

  assign beat_vld = act_q;
  assign beat_end = act_q && at_final;

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> (beat_vld && beat_col == $past(cmd_col)));

  assert_halt_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !cmd_go) |=> !beat_vld);

  assert_end_needs_vld_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_end |-> beat_vld);

  assert_end_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_end && !cmd_go) |=> !beat_vld);

  assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !page_q && !beat_end && !cmd_go && !halt)
      |=> ((beat_col & ~mask_q) == $past(beat_col & ~mask_q)));

  assert_page_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && page_q && !cmd_go && !halt)
      |=> (beat_vld && !beat_end && beat_col == COL_W'($past(beat_col) + 1'b1)));

endmodule

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;

  typedef struct packed {
    logic [2:0]      code;
    logic            ilv;
    logic [3:0]      n;
    logic [7:0][8:0] a;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{3'd2, 1'b0, 4'd4, {9'd102, 9'd103, 9'd100, 9'd101, 9'd0, 9'd0, 9'd0, 9'd0}},
    '{3'd3, 1'b1, 4'd8, {9'd13, 9'd12, 9'd15, 9'd14, 9'd9, 9'd8, 9'd11, 9'd10}},
    '{3'd3, 1'b0, 4'd8, {9'd13, 9'd14, 9'd15, 9'd8, 9'd9, 9'd10, 9'd11, 9'd12}},
    '{3'd1, 1'b1, 4'd2, {9'd7, 9'd6, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0}},
    '{3'd1, 1'b0, 4'd2, {9'd6, 9'd7, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0}},
    '{3'd2, 1'b1, 4'd4, {9'd301, 9'd300, 9'd303, 9'd302, 9'd0, 9'd0, 9'd0, 9'd0}},
    '{3'd0, 1'b0, 4'd1, {9'd200, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0}},
    '{3'd5, 1'b1, 4'd1, {9'd55, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0}},
    '{3'd3, 1'b0, 4'd8, {9'd511, 9'd504, 9'd505, 9'd506, 9'd507, 9'd508, 9'd509, 9'd510}}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_go, cmd_ilv, halt;
  logic [8:0] cmd_col;
  logic [2:0] cmd_len;
  logic       beat_vld, beat_end;
  logic [8:0] beat_col;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  burst_col_gen u0 (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_col(cmd_col),
    .cmd_len(cmd_len), .cmd_ilv(cmd_ilv), .halt(halt),
    .beat_vld(beat_vld), .beat_col(beat_col), .beat_end(beat_end)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic go(input logic [2:0] len, input logic il, input logic [8:0] col);
    cmd_len = len; cmd_ilv = il; cmd_col = col; cmd_go = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_go = 1'b0; halt = 1'b0;
    cmd_col = '0; cmd_len = '0; cmd_ilv = 1'b0;
    repeat (3) @(negedge clk);
    chk(!beat_vld, "R1 vld in reset", int'(beat_vld), 0);
    chk(!beat_end, "R1 end in reset", int'(beat_end), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!beat_vld, "R1 vld idle", int'(beat_vld), 0);

    // Table walk: R3 R4 R5 R6 R9 R10
    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = TBL[i];
      automatic string rq = (v.code > 3'd3) ? "R9" : (v.n == 4'd1) ? "R10" : v.ilv ? "R5" : "R4";
      automatic logic [8:0] m = 9'(v.n) - 9'd1;
      go(v.code, v.ilv, v.a[7]);
      for (int k = 0; k < int'(v.n); k++) begin
        chk(beat_vld, "R3 vld", int'(beat_vld), 1);
        chk(beat_col == v.a[7-k], rq, int'(beat_col), int'(v.a[7-k]));
        chk((beat_col & ~m) == (v.a[7] & ~m), "R6", int'(beat_col & ~m), int'(v.a[7] & ~m));
        chk(beat_end == (k == int'(v.n) - 1), "R3 end", int'(beat_end), int'(k == int'(v.n) - 1));
        @(negedge clk);
      end
      chk(!beat_vld, "R3 done", int'(beat_vld), 0);
      @(negedge clk);
    end

    // Full page with wrap, interleave select ignored, then halt: R7 R8
    go(3'd7, 1'b1, 9'd509);
    for (int k = 0; k < 6; k++) begin
      automatic int e = (509 + k) % 512;
      chk(beat_vld && beat_col == 9'(e), "R7 page", int'(beat_col), e);
      chk(!beat_end, "R7 no end", int'(beat_end), 0);
      if (k == 5) halt = 1'b1;
      @(negedge clk);
    end
    halt = 1'b0;
    chk(!beat_vld, "R8 halt page", int'(beat_vld), 0);
    @(negedge clk);

    // Restart mid-burst: R2
    go(3'd3, 1'b0, 9'd0);
    chk(beat_col == 9'd0, "R2 first", int'(beat_col), 0);
    @(negedge clk);
    chk(beat_col == 9'd1, "R2 second", int'(beat_col), 1);
    go(3'd2, 1'b0, 9'd42);
    for (int k = 0; k < 4; k++) begin
      automatic int e = 40 + ((2 + k) % 4);
      chk(beat_vld && beat_col == 9'(e), "R2 restart", int'(beat_col), e);
      chk(beat_end == (k == 3), "R2 end", int'(beat_end), int'(k == 3));
      @(negedge clk);
    end
    chk(!beat_vld, "R2 done", int'(beat_vld), 0);

    // Go and halt together: new burst wins (R8)
    halt = 1'b1;
    go(3'd1, 1'b0, 9'd20);
    halt = 1'b0;
    chk(beat_vld && beat_col == 9'd20, "R8 go wins", int'(beat_col), 20);
    @(negedge clk);
    chk(beat_col == 9'd21 && beat_end, "R8 go wins 2", int'(beat_col), 21);
    @(negedge clk);

    // Halt of a bounded burst mid-way (R8)
    go(3'd3, 1'b1, 9'd64);
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    chk(!beat_vld, "R8 halt bounded", int'(beat_vld), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule